// File: doc/BRIEF.md
# Shared-Bus Multicycle 16-bit Datapath

This block is the data side of a small multicycle processor. Every transfer between its storage elements crosses a single 16-bit internal bus. The controller picks the one source that drives the bus in a cycle and raises load or write strobes on whichever destinations should capture the value at the next rising edge.

The storage elements are:
- a program counter, an instruction register and a memory address register;
- two ALU operand latches and a one-bit zero flag;
- a sixteen-entry register file whose index comes from one of three fields of the held instruction;
- a 1024-word, word-addressed memory.

The block sends the held opcode and the zero flag back to the controller. It also shows the live bus value so the environment can watch every transfer. A separate preload port fills memory before reset is released.

The controller is external and is not part of this block. It sequences the strobes to carry out fetch, arithmetic, loads, stores and branches. Instruction fetch policy belongs to the controller as well.

Top module: `sbus_datapath`

## Requirements
- R1: While `rst_n` is low at a rising edge, PC, IR, MAR, both ALU latches and the zero flag clear to 0. Afterwards `opcode` reads 0, `zero_flag` reads 0, and the ALU sum of the two latches reads 0.
- R2: The bus carries the value of the single asserted drive strobe's source. When no drive strobe is asserted, the bus reads 0x0000.
- R3: `drv_imm` places IR bits 4..0 on the bus, sign-extended from bit 4 to 16 bits.
- R4: `rf_sel` picks the register index from the IR:
  - 00 uses bits 12..9;
  - 01 uses bits 8..5;
  - 10 uses bits 4..1;
  - 11 reads 0 and discards writes.
  `drv_rf` reads the selected register, and `wr_rf` writes the bus into it at the edge.
- R5: Register index 0 always reads 0, and any write to it is discarded.
- R6: `drv_alu` places the ALU result on the bus, modulo 2^16. The `alu_fn` codes are:
  - 00: A+B
  - 01: NOT(A AND B)
  - 10: A−B
  - 11: A+1
- R7: Memory is addressed by the low 10 bits of MAR. `drv_mem` places the addressed word on the bus, and `wr_mem` stores the bus value there at the edge.
- R8: With `ld_z` high, `zero_flag` becomes 1 at the edge if the bus is 0x0000 and becomes 0 otherwise. With `ld_z` low it holds.
- R9: `opcode` equals IR bits 15..13.
- R10: Each of PC, IR, MAR, A and B captures the bus only at a rising edge with its own load strobe high, and holds otherwise.
- R11: With `pre_we` high, `pre_data` is written at `pre_addr` at the edge, taking priority over `wr_mem`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_imm | input | 1 | Drive sign-extended IR offset onto the bus |
| drv_rf | input | 1 | Drive the selected register onto the bus |
| drv_mem | input | 1 | Drive the memory word at MAR onto the bus |
| drv_alu | input | 1 | Drive the ALU result onto the bus |
| drv_pc | input | 1 | Drive PC onto the bus |
| ld_pc | input | 1 | Load PC from the bus |
| ld_ir | input | 1 | Load IR from the bus |
| ld_mar | input | 1 | Load MAR from the bus |
| ld_a | input | 1 | Load ALU operand A from the bus |
| ld_b | input | 1 | Load ALU operand B from the bus |
| ld_z | input | 1 | Latch the bus-equals-zero test |
| wr_rf | input | 1 | Write the bus into the selected register |
| wr_mem | input | 1 | Write the bus into memory at MAR |
| rf_sel | input | 2 | Register index field select |
| alu_fn | input | 2 | ALU function code |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 10 | Preload word address |
| pre_data | input | 16 | Preload word |
| opcode | output | 3 | IR bits 15..13 |
| zero_flag | output | 1 | Latched zero flag |
| bus_mon | output | 16 | Current bus value |

## Verification
The assertions assume the controller raises at most one drive strobe per cycle, and one of them checks exactly that. They also assume that preloading happens only while reset is held or before any `wr_mem` use.

The bench drives strobes only through a task that accepts a single drive code, so the one-hot condition holds by construction of the stimulus. It preloads memory only while `rst_n` is low. Every register or memory word it reads has been written earlier in the same run, so no comparison depends on uninitialised storage.

// File: rtl/sbus_pkg.sv
// Shared constants and types for the shared-bus datapath.
// Assumes a 16-bit instruction layout with fixed field positions.
package sbus_pkg;
    localparam int WORD_W    = 16;
    localparam int NREG      = 16;
    localparam int MEM_WORDS = 1024;
    localparam int OPC_W     = 3;
    localparam int IMM_W     = 5;
    localparam int FX_LSB    = 9;
    localparam int FY_LSB    = 5;
    localparam int FZ_LSB    = 1;

    // Bus source positions in the drive vector
    localparam int SRC_IMM = 0;
    localparam int SRC_RF  = 1;
    localparam int SRC_MEM = 2;
    localparam int SRC_ALU = 3;
    localparam int SRC_PC  = 4;
    localparam int SRC_N   = 5;

    typedef enum logic [1:0] {
        SEL_X    = 2'b00,
        SEL_Y    = 2'b01,
        SEL_Z    = 2'b10,
        SEL_NONE = 2'b11
    } rsel_e;

    typedef enum logic [1:0] {
        FN_ADD  = 2'b00,
        FN_NAND = 2'b01,
        FN_SUB  = 2'b10,
        FN_INC  = 2'b11
    } alufn_e;
endpackage

// File: rtl/sbus_busmux.sv
// AND-OR bus selector: ORs together each source gated by its drive bit.
// Assumes at most one drive bit is set; with none set the bus is zero.
module sbus_busmux #(
    parameter int W = 16,
    parameter int N = 5
) (
    input  logic [N-1:0] drv,
    input  logic [W-1:0] src [N],
    output logic [W-1:0] bus
);
    logic [W-1:0] part [N+1];

    assign part[0] = '0;
    generate
        for (genvar g = 0; g < N; g++) begin : g_src
            // accumulate one gated source per stage
            assign part[g+1] = part[g] | (src[g] & {W{drv[g]}});
        end
    endgenerate
    assign bus = part[N];
endmodule

// File: rtl/sbus_regfile.sv
// Register file, one read port and one write port.
// Entry 0 is a constant zero; writes to it are dropped.
module sbus_regfile #(
    parameter int W = 16,
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data
);
    logic [W-1:0] ent [N];

    assign ent[0] = '0;
    generate
        for (genvar g = 1; g < N; g++) begin : g_ent
            // capture the write data when this entry is addressed
            always_ff @(posedge clk) begin
                if (we && wr_idx == IW'(g)) begin
                    ent[g] <= wr_data;
                end
            end
        end
    endgenerate

    // asynchronous read of the indexed entry
    assign rd_data = ent[rd_idx];
endmodule

// File: rtl/sbus_alu.sv
// Four-function ALU on the two operand latches; results wrap modulo 2^W.
module sbus_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   fn,
    output logic [W-1:0] y
);
    import sbus_pkg::*;

    // select the function result
    always_comb begin
        unique case (alufn_e'(fn))
            FN_ADD:  y = a + b;
            FN_NAND: y = ~(a & b);
            FN_SUB:  y = a - b;
            FN_INC:  y = a + W'(1);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/sbus_wordmem.sv
// Word-addressed memory with asynchronous read and a synchronous write.
// A preload port takes priority over the bus-side write.
module sbus_wordmem #(
    parameter int W     = 16,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [W-1:0]  pre_data
);
    logic [W-1:0] arr [DEPTH];

    // preload first, otherwise the datapath write
    always_ff @(posedge clk) begin
        if (pre_we) begin
            arr[pre_addr] <= pre_data;
        end else if (we) begin
            arr[addr] <= wdata;
        end
    end

    // asynchronous read at the current address
    assign rdata = arr[addr];
endmodule

// File: rtl/sbus_datapath.sv
// Top of the shared-bus datapath: state registers, bus selection and
// field decode. Assumes an external controller raises at most one
// drive strobe per cycle and preloads memory only around reset.
module sbus_datapath #(
    parameter int W         = sbus_pkg::WORD_W,
    parameter int NREG      = sbus_pkg::NREG,
    parameter int MEM_WORDS = sbus_pkg::MEM_WORDS,
    localparam int IDX_W    = $clog2(NREG),
    localparam int ADDR_W   = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_imm,
    input  logic              drv_rf,
    input  logic              drv_mem,
    input  logic              drv_alu,
    input  logic              drv_pc,
    input  logic              ld_pc,
    input  logic              ld_ir,
    input  logic              ld_mar,
    input  logic              ld_a,
    input  logic              ld_b,
    input  logic              ld_z,
    input  logic              wr_rf,
    input  logic              wr_mem,
    input  logic [1:0]        rf_sel,
    input  logic [1:0]        alu_fn,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [W-1:0]      pre_data,
    output logic [sbus_pkg::OPC_W-1:0] opcode,
    output logic              zero_flag,
    output logic [W-1:0]      bus_mon
);
    import sbus_pkg::*;

    logic [W-1:0]      pc_q, ir_q, a_q, b_q;
    logic [ADDR_W-1:0] mar_q;
    logic              z_q;
    logic [SRC_N-1:0]  drv_vec;
    logic [W-1:0]      src [SRC_N];
    logic [W-1:0]      bus_w, rf_rd, alu_y, mem_rd;
    logic [IDX_W-1:0]  rf_idx;
    logic              idx_ok;

    assign drv_vec = {drv_pc, drv_alu, drv_mem, drv_rf, drv_imm};

    // pick the register index field named by rf_sel
    always_comb begin
        idx_ok = 1'b1;
        unique case (rsel_e'(rf_sel))
            SEL_X:   rf_idx = ir_q[FX_LSB +: IDX_W];
            SEL_Y:   rf_idx = ir_q[FY_LSB +: IDX_W];
            SEL_Z:   rf_idx = ir_q[FZ_LSB +: IDX_W];
            default: begin
                rf_idx = '0;
                idx_ok = 1'b0;
            end
        endcase
    end

    sbus_regfile #(.W(W), .N(NREG)) u_rf (
        .clk     (clk),
        .rd_idx  (rf_idx),
        .rd_data (rf_rd),
        .we      (wr_rf && idx_ok),
        .wr_idx  (rf_idx),
        .wr_data (bus_w)
    );

    sbus_alu #(.W(W)) u_alu (
        .a  (a_q),
        .b  (b_q),
        .fn (alu_fn),
        .y  (alu_y)
    );

    sbus_wordmem #(.W(W), .DEPTH(MEM_WORDS)) u_mem (
        .clk      (clk),
        .addr     (mar_q),
        .we       (wr_mem),
        .wdata    (bus_w),
        .rdata    (mem_rd),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data)
    );

    // gather the bus sources in drive-vector order
    assign src[SRC_IMM] = {{(W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign src[SRC_RF]  = idx_ok ? rf_rd : '0;
    assign src[SRC_MEM] = mem_rd;
    assign src[SRC_ALU] = alu_y;
    assign src[SRC_PC]  = pc_q;

    sbus_busmux #(.W(W), .N(SRC_N)) u_bus (
        .drv (drv_vec),
        .src (src),
        .bus (bus_w)
    );

    // state registers: clear on reset, otherwise load from the bus
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            ir_q  <= '0;
            mar_q <= '0;
            a_q   <= '0;
            b_q   <= '0;
            z_q   <= 1'b0;
        end else begin
            if (ld_pc)  pc_q  <= bus_w;
            if (ld_ir)  ir_q  <= bus_w;
            if (ld_mar) mar_q <= bus_w[ADDR_W-1:0];
            if (ld_a)   a_q   <= bus_w;
            if (ld_b)   b_q   <= bus_w;
            if (ld_z)   z_q   <= (bus_w == '0);
        end
    end

    assign opcode    = ir_q[W-1 -: OPC_W];
    assign zero_flag = z_q;
    assign bus_mon   = bus_w;
endmodule

// File: rtl/sbus_datapath_chk.sv
// Property checker for sbus_datapath, attached by bind below.
// Assumes the controller keeps the drive strobes one-hot or idle.
module sbus_datapath_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [4:0]   drv_vec,
    input logic         ld_z,
    input logic         ld_ir,
    input logic         ld_pc,
    input logic [1:0]   rf_sel,
    input logic [3:0]   fx,
    input logic [4:0]   imm,
    input logic [W-1:0] pc_q,
    input logic [W-1:0] bus,
    input logic         zero_flag,
    input logic [2:0]   opcode
);
    p_bus_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_vec));

    p_idle_bus_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_vec == 5'b0) |-> (bus == '0));

    p_imm_sext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_vec == 5'b00001) |-> (bus == {{(W-5){imm[4]}}, imm}));

    p_sel_none_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_vec == 5'b00010 && rf_sel == 2'b11) |-> (bus == '0));

    p_reg0_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_vec == 5'b00010 && rf_sel == 2'b00 && fx == 4'd0) |-> (bus == '0));

    p_zero_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_z |=> (zero_flag == ($past(bus) == '0)));

    p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_z |=> $stable(zero_flag));

    p_opcode_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ir |=> (opcode == $past(bus[W-1 -: 3])));

    p_pc_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_pc |=> $stable(pc_q));
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .drv_vec   (drv_vec),
    .ld_z      (ld_z),
    .ld_ir     (ld_ir),
    .ld_pc     (ld_pc),
    .rf_sel    (rf_sel),
    .fx        (ir_q[12:9]),
    .imm       (ir_q[4:0]),
    .pc_q      (pc_q),
    .bus       (bus_w),
    .zero_flag (zero_flag),
    .opcode    (opcode)
);

// File: tb/sbus_datapath_test.sv
// Bench for sbus_datapath: a behavioural model predicts the bus, zero
// flag and opcode every cycle and compares them with the outputs.
module sbus_datapath_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        drv_imm = 0, drv_rf = 0, drv_mem = 0, drv_alu = 0, drv_pc = 0;
    logic        ld_pc = 0, ld_ir = 0, ld_mar = 0, ld_a = 0, ld_b = 0, ld_z = 0;
    logic        wr_rf = 0, wr_mem = 0;
    logic [1:0]  rf_sel = 0, alu_fn = 0;
    logic        pre_we = 0;
    logic [9:0]  pre_addr = 0;
    logic [15:0] pre_data = 0;
    logic [2:0]  opcode;
    logic        zero_flag;
    logic [15:0] bus_mon;

    int total = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [4:0] D_NO = 5'b00000, D_IMM = 5'b00001, D_RF = 5'b00010,
                           D_MEM = 5'b00100, D_ALU = 5'b01000, D_PC = 5'b10000;
    localparam logic [5:0] L_NO = 6'b0, L_PC = 6'b000001, L_IR = 6'b000010,
                           L_MAR = 6'b000100, L_A = 6'b001000, L_B = 6'b010000,
                           L_Z = 6'b100000;

    // reference state
    logic [15:0] m_pc, m_ir, m_a, m_b;
    logic [9:0]  m_mar;
    logic        m_z;
    logic [15:0] m_rf [16];
    logic [15:0] m_mem [1024];

    always #5 clk = ~clk;

    sbus_datapath uut (
        .clk(clk), .rst_n(rst_n),
        .drv_imm(drv_imm), .drv_rf(drv_rf), .drv_mem(drv_mem),
        .drv_alu(drv_alu), .drv_pc(drv_pc),
        .ld_pc(ld_pc), .ld_ir(ld_ir), .ld_mar(ld_mar),
        .ld_a(ld_a), .ld_b(ld_b), .ld_z(ld_z),
        .wr_rf(wr_rf), .wr_mem(wr_mem), .rf_sel(rf_sel), .alu_fn(alu_fn),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .opcode(opcode), .zero_flag(zero_flag), .bus_mon(bus_mon)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int sel_idx(input logic [1:0] sel);
        case (sel)
            2'd0: return int'(m_ir[12:9]);
            2'd1: return int'(m_ir[8:5]);
            2'd2: return int'(m_ir[4:1]);
            default: return -1;
        endcase
    endfunction

    function automatic logic [15:0] model_bus(input logic [4:0] d, input logic [1:0] sel,
                                             input logic [1:0] fn);
        int k;
        case (d)
            D_IMM: return {{11{m_ir[4]}}, m_ir[4:0]};
            D_RF: begin
                k = sel_idx(sel);
                return (k <= 0) ? 16'h0000 : m_rf[k];
            end
            D_MEM: return m_mem[m_mar];
            D_ALU: case (fn)
                2'd0: return m_a + m_b;
                2'd1: return ~(m_a & m_b);
                2'd2: return m_a - m_b;
                default: return m_a + 16'd1;
            endcase
            D_PC: return m_pc;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] mk(input logic [2:0] op, input logic [3:0] rx,
                                       input logic [3:0] ry, input logic [4:0] low);
        return {op, rx, ry, low};
    endfunction

    // one controller cycle: drive, compare bus, step model at the edge, compare state
    task automatic cyc(input logic [4:0] d, input logic [5:0] l, input logic wrf,
                       input logic wm, input logic [1:0] sel, input logic [1:0] fn,
                       input string tag);
        logic [15:0] eb;
        logic [9:0]  old_mar;
        int          k;
        string       t;
        @(negedge clk);
        {drv_pc, drv_alu, drv_mem, drv_rf, drv_imm} = d;
        {ld_z, ld_b, ld_a, ld_mar, ld_ir, ld_pc} = l;
        wr_rf = wrf; wr_mem = wm; rf_sel = sel; alu_fn = fn;
        #1;
        eb = model_bus(d, sel, fn);
        k = sel_idx(sel);
        t = tag;
        if (t == "") begin
            case (d)
                D_IMM: t = "R3";
                D_RF:  t = (k == 0) ? "R5" : "R4";
                D_MEM: t = "R7";
                D_ALU: t = "R6";
                D_PC:  t = "R10";
                default: t = "R2";
            endcase
        end
        check(t, bus_mon, eb);
        old_mar = m_mar;
        @(posedge clk);
        #1;
        if (l[0]) m_pc = eb;
        if (l[1]) m_ir = eb;
        if (l[2]) m_mar = eb[9:0];
        if (l[3]) m_a = eb;
        if (l[4]) m_b = eb;
        if (l[5]) m_z = (eb == 16'h0000);
        if (wrf && k > 0) m_rf[k] = eb;
        if (wm) m_mem[old_mar] = eb;
        check("R8", {15'b0, zero_flag}, {15'b0, m_z});
        check("R9", {13'b0, opcode}, {13'b0, m_ir[15:13]});
        {drv_pc, drv_alu, drv_mem, drv_rf, drv_imm} = D_NO;
        {ld_z, ld_b, ld_a, ld_mar, ld_ir, ld_pc} = L_NO;
        wr_rf = 0; wr_mem = 0;
    endtask

    // R11: preload one word while reset is held
    task automatic preload(input logic [9:0] a, input logic [15:0] v);
        @(negedge clk);
        pre_we = 1; pre_addr = a; pre_data = v;
        @(posedge clk);
        #1;
        pre_we = 0;
        m_mem[a] = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        #1;
        m_pc = 0; m_ir = 0; m_mar = 0; m_a = 0; m_b = 0; m_z = 0;
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic fetch();
        cyc(D_PC,  L_MAR, 0, 0, 2'd0, 2'd0, "");
        cyc(D_MEM, L_IR,  0, 0, 2'd0, 2'd0, "R11");
        cyc(D_PC,  L_A,   0, 0, 2'd0, 2'd0, "");
        cyc(D_ALU, L_PC,  0, 0, 2'd0, 2'd3, "R6");
    endtask

    task automatic reset_checks();
        cyc(D_NO,  L_NO, 0, 0, 2'd0, 2'd0, "R1");
        cyc(D_PC,  L_NO, 0, 0, 2'd0, 2'd0, "R1");
        cyc(D_ALU, L_NO, 0, 0, 2'd0, 2'd0, "R1");
        cyc(D_IMM, L_NO, 0, 0, 2'd0, 2'd0, "R1");
    endtask

    initial begin
        m_pc = 0; m_ir = 0; m_mar = 0; m_a = 0; m_b = 0; m_z = 0;
        // R11: program and data loaded through the preload port
        preload(10'd0,    mk(3'b011, 4'd3, 4'd0, 5'h1F));
        preload(10'd1,    mk(3'b010, 4'd4, 4'd3, 5'h1E));
        preload(10'd2,    mk(3'b000, 4'd0, 4'd3, 5'h1D));
        preload(10'd3,    mk(3'b111, 4'd0, 4'd0, 5'h05));
        preload(10'd5,    mk(3'b101, 4'd7, 4'd0, 5'h10));
        preload(10'd1023, 16'h1234);
        preload(10'd1022, 16'hF00F);
        preload(10'd1021, 16'hBEEF);
        preload(10'd1008, 16'h8000);
        do_reset();
        reset_checks();

        // I0: r3 <- mem[-1]
        fetch();
        cyc(D_IMM, L_MAR, 0, 0, 2'd0, 2'd0, "R3");
        cyc(D_MEM, L_NO,  1, 0, 2'd0, 2'd0, "R7");
        cyc(D_RF,  L_NO,  0, 0, 2'd0, 2'd0, "R4");

        // I1: r4 <- mem[-2], ALU functions, result into the third field (r15)
        fetch();
        cyc(D_IMM, L_MAR, 0, 0, 2'd0, 2'd0, "");
        cyc(D_MEM, L_NO,  1, 0, 2'd0, 2'd0, "");
        cyc(D_RF,  L_A,   0, 0, 2'd1, 2'd0, "R4");
        cyc(D_RF,  L_B,   0, 0, 2'd0, 2'd0, "R4");
        for (int f = 0; f < 4; f++) cyc(D_ALU, L_Z, 0, 0, 2'd0, 2'(f), "R6");
        cyc(D_ALU, L_NO, 1, 0, 2'd2, 2'd2, "R6");
        cyc(D_RF,  L_NO, 0, 0, 2'd2, 2'd0, "R4");
        cyc(D_RF,  L_B,  0, 0, 2'd1, 2'd0, "R10");
        cyc(D_ALU, L_Z,  0, 0, 2'd0, 2'd2, "R6");
        cyc(D_NO,  L_NO, 0, 0, 2'd0, 2'd0, "R2");
        cyc(D_PC,  L_NO, 0, 0, 2'd0, 2'd0, "R10");

        // I2: writes to r0 and through the unused select are dropped; store
        fetch();
        cyc(D_IMM, L_MAR, 0, 0, 2'd0, 2'd0, "");
        cyc(D_MEM, L_NO,  1, 0, 2'd0, 2'd0, "R5");
        cyc(D_RF,  L_Z,   0, 0, 2'd0, 2'd0, "R5");
        cyc(D_MEM, L_NO,  1, 0, 2'd3, 2'd0, "R4");
        cyc(D_RF,  L_NO,  0, 0, 2'd3, 2'd0, "R4");
        cyc(D_RF,  L_NO,  0, 0, 2'd1, 2'd0, "R4");
        cyc(D_RF,  L_NO,  0, 1, 2'd1, 2'd0, "R7");
        cyc(D_MEM, L_Z,   0, 0, 2'd0, 2'd0, "R7");
        cyc(D_NO,  L_Z,   0, 0, 2'd0, 2'd0, "R2");

        // I3: jump to 5 via the offset; I5 uses a negative offset address
        fetch();
        cyc(D_IMM, L_NO, 0, 0, 2'd0, 2'd0, "R3");
        cyc(D_IMM, L_PC, 0, 0, 2'd0, 2'd0, "R3");
        cyc(D_PC,  L_NO, 0, 0, 2'd0, 2'd0, "R10");
        fetch();
        cyc(D_IMM, L_MAR, 0, 0, 2'd0, 2'd0, "R3");
        cyc(D_MEM, L_NO,  1, 0, 2'd0, 2'd0, "R7");
        cyc(D_RF,  L_A,   0, 0, 2'd0, 2'd0, "R4");
        cyc(D_ALU, L_NO,  0, 0, 2'd0, 2'd3, "R6");
        cyc(D_ALU, L_Z,   0, 0, 2'd0, 2'd0, "R6");
        cyc(D_ALU, L_NO,  0, 0, 2'd0, 2'd1, "R6");

        // R1: reset in mid-run clears the state registers
        do_reset();
        reset_checks();
        cyc(D_RF,  L_NO, 0, 0, 2'd0, 2'd0, "R1");
        cyc(D_MEM, L_NO, 0, 0, 2'd0, 2'd0, "R1");

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule